// File: doc/BRIEF.md
# Strided Interleaved Memory Bank Scheduler

This block serves one vector memory load at a time. A request names a starting word address, a signed step between elements and an element count. The block walks the elements in index order, forms each element's word address, and sends it to one of sixteen interleaved banks. The bank is picked by the low four address bits. A bank that has just accepted an access needs several cycles to recover. While the bank wanted by the next element is recovering, address generation waits. Elements are never reordered to fill the gap.

Each accepted access returns its word a fixed number of cycles later. The word is tagged with its element index, so a vector register write port can drop it into the right slot. The word store is a plain behavioural array inside the block. A fill port loads that array while no request is running. The block raises a one-cycle completion pulse in the same cycle as the final element's returned word.

Top module: `stride_bank_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `issueValid` and `rdValid` are all low.
- R2: Element i reads word address (reqBase + i × reqStride) modulo 1024. `rdData` equals the word stored at that address.
- R3: The bank of an address is its value modulo 16. Two accesses to the same bank are at least 4 cycles apart. An element whose bank is still recovering is held until the bank is free, and then it issues.
- R4: With a stride of 1, elements issue on consecutive cycles. Element 0 issues in the cycle after `start` is sampled.
- R5: With a stride that is a multiple of 16, including 0, elements issue exactly one every 4 cycles.
- R6: The word for an element appears on `rdValid`/`rdData` exactly 12 cycles after that element's issue cycle.
- R7: The number of elements returned is `reqLen`, capped at 64. If `reqLen` is 0, no data is returned, `busy` stays low and `done` pulses in the cycle after `start`.
- R8: `reqStride` is a 10-bit two's-complement value. Address arithmetic wraps modulo 1024 in both directions.
- R9: `done` is a single-cycle pulse in the same cycle as the last element's `rdValid`. `busy` is high from the cycle after `start` up to the cycle before `done`. `issueValid` occurs only while `busy` is high.
- R10: A `start` pulse seen while `busy` is high has no effect. No extra elements are returned, and the running request's data and timing are unchanged.
- R11: Returned words appear in strictly ascending element order. `rdIdx` counts 0, 1, 2, … within a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled only while idle |
| reqBase | input | 10 | First element word address |
| reqStride | input | 10 | Signed element step in words |
| reqLen | input | 7 | Element count, capped at 64 |
| fillEn | input | 1 | Write enable into the word store, honoured only while idle |
| fillAddr | input | 10 | Word store write address |
| fillData | input | 32 | Word store write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| issueValid | output | 1 | An element is accepted by its bank this cycle |
| issueAddr | output | 10 | Word address being generated; meaningful when issueValid is high |
| rdValid | output | 1 | Returned word valid |
| rdIdx | output | 6 | Element index of the returned word |
| rdData | output | 32 | Returned word |

## Verification
Some properties are checked on every cycle. The same-bank recovery gap is checked on every issue, and `done` is checked to last only one cycle. Issues are checked to occur only while `busy` is high, returned indices must run in sequence, and no request may return more than 64 words. The absolute cycle timing is left to the bench. For each stride pattern (unit, bank-conflicting, half-conflicting, negative and wrapping), it compares every returned word's arrival cycle and data against a bank-occupancy model it builds from the requirements. The bench scenarios also cover the length cap, the empty request and a `start` pulse injected during a run.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // latch base and stride for a new request
    logic issue;  // current element is accepted by its bank this cycle
  } sbsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } sbsState_t;

endpackage

// File: rtl/sbs_bank_table.sv
// One recovery counter per bank; reports whether the queried bank is free.
module sbs_bank_table #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int BANK_BUSY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [BANK_W-1:0] queryBank,
  output logic              bankFree
);

  localparam int CNT_W = $clog2(BANK_BUSY) + 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BANK_BUSY - 1);

  logic [NUM_BANKS-1:0] freeVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] recoverCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        recoverCnt <= '0;
      end else if (issue && (queryBank == BANK_W'(b))) begin
        recoverCnt <= RELOAD;
      end else if (recoverCnt != '0) begin
        recoverCnt <= recoverCnt - CNT_W'(1);
      end
    end

    assign freeVec[b] = (recoverCnt == '0);
  end

  assign bankFree = freeVec[queryBank];

endmodule

// File: rtl/sbs_ctrl.sv
// Request sequencing: element counting, stall on busy bank, drain, done.
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             bankFree,
  input  logic             tailValid,
  input  logic [IDX_W-1:0] tailIdx,
  output sbsStrobe_t       strobe,
  output logic [IDX_W-1:0] elemIdx,
  output logic             busy,
  output logic             done
);

  sbsState_t        state;
  logic [IDX_W-1:0] lastIdx;
  logic [LEN_W-1:0] lenClamp;

  assign lenClamp = (reqLen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : reqLen;

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && start && (lenClamp != '0);
    strobe.issue = (state == ST_ISSUE) && bankFree;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (lenClamp == '0) begin
              done <= 1'b1;
            end else begin
              state   <= ST_ISSUE;
              elemIdx <= '0;
              lastIdx <= IDX_W'(lenClamp - LEN_W'(1));
            end
          end
        end
        ST_ISSUE: begin
          if (bankFree) begin
            if (elemIdx == lastIdx) begin
              state <= ST_DRAIN;
            end else begin
              elemIdx <= elemIdx + IDX_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (tailValid && (tailIdx == lastIdx)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbs_datapath.sv
// Address generation, bank occupancy, return pipeline and word store.
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int BANK_BUSY = 4,
  parameter int READ_LAT  = 12,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbsStrobe_t        strobe,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqStride,
  input  logic              fillEn,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              bankFree,
  output logic [ADDR_W-1:0] issueAddr,
  output logic              tailValid,
  output logic [IDX_W-1:0]  tailIdx,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  localparam int PIPE_N    = READ_LAT - 1;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] strideReg;

  // Address walk: modulo-2^ADDR_W wrap comes from the register width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      strideReg <= '0;
    end else if (strobe.load) begin
      curAddr   <= reqBase;
      strideReg <= reqStride;
    end else if (strobe.issue) begin
      curAddr <= curAddr + strideReg;
    end
  end

  assign issueAddr = curAddr;

  sbs_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .BANK_BUSY (BANK_BUSY)
  ) u_bankTable (
    .clk       (clk),
    .rstN      (rstN),
    .issue     (strobe.issue),
    .queryBank (curAddr[BANK_W-1:0]),
    .bankFree  (bankFree)
  );

  // Fixed-latency return pipeline
  logic              pipeV    [PIPE_N];
  logic [IDX_W-1:0]  pipeIdx  [PIPE_N];
  logic [ADDR_W-1:0] pipeAddr [PIPE_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < PIPE_N; s++) begin
        pipeV[s]    <= 1'b0;
        pipeIdx[s]  <= '0;
        pipeAddr[s] <= '0;
      end
    end else begin
      pipeV[0]    <= strobe.issue;
      pipeIdx[0]  <= elemIdx;
      pipeAddr[0] <= curAddr;
      for (int s = 1; s < PIPE_N; s++) begin
        pipeV[s]    <= pipeV[s-1];
        pipeIdx[s]  <= pipeIdx[s-1];
        pipeAddr[s] <= pipeAddr[s-1];
      end
    end
  end

  assign tailValid = pipeV[PIPE_N-1];
  assign tailIdx   = pipeIdx[PIPE_N-1];

  // Behavioural word store
  logic [DATA_W-1:0] wordStore [MEM_WORDS];

  always_ff @(posedge clk) begin
    if (fillEn) begin
      wordStore[fillAddr] <= fillData;
    end
    rdData <= wordStore[pipeAddr[PIPE_N-1]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdIdx   <= '0;
    end else begin
      rdValid <= pipeV[PIPE_N-1];
      rdIdx   <= pipeIdx[PIPE_N-1];
    end
  end

endmodule

// File: rtl/stride_bank_sched.sv
module stride_bank_sched
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int READ_LAT  = 12,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(MAX_VL),
  localparam int LEN_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqStride,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              fillEn,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              busy,
  output logic              done,
  output logic              issueValid,
  output logic [ADDR_W-1:0] issueAddr,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  sbsStrobe_t       strobe;
  logic [IDX_W-1:0] elemIdx;
  logic             bankFree;
  logic             tailValid;
  logic [IDX_W-1:0] tailIdx;

  sbs_ctrl #(
    .MAX_VL (MAX_VL),
    .IDX_W  (IDX_W),
    .LEN_W  (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .reqLen    (reqLen),
    .bankFree  (bankFree),
    .tailValid (tailValid),
    .tailIdx   (tailIdx),
    .strobe    (strobe),
    .elemIdx   (elemIdx),
    .busy      (busy),
    .done      (done)
  );

  sbs_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .BANK_BUSY (BANK_BUSY),
    .READ_LAT  (READ_LAT),
    .IDX_W     (IDX_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .elemIdx   (elemIdx),
    .reqBase   (reqBase),
    .reqStride (reqStride),
    .fillEn    (fillEn && !busy),
    .fillAddr  (fillAddr),
    .fillData  (fillData),
    .bankFree  (bankFree),
    .issueAddr (issueAddr),
    .tailValid (tailValid),
    .tailIdx   (tailIdx),
    .rdValid   (rdValid),
    .rdIdx     (rdIdx),
    .rdData    (rdData)
  );

  assign issueValid = strobe.issue;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int MAX_VL    = 64,
  parameter int IDX_W     = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              issueValid,
  input logic [ADDR_W-1:0] issueAddr,
  input logic              rdValid,
  input logic [IDX_W-1:0]  rdIdx
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [31:0]          cycleNo;
  logic [31:0]          lastIssue [NUM_BANKS];
  logic [NUM_BANKS-1:0] seenBank;
  logic [IDX_W:0]       retCnt;
  logic [BANK_W-1:0]    curBank;

  assign curBank = issueAddr[BANK_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleNo  <= '0;
      seenBank <= '0;
      retCnt   <= '0;
      for (int b = 0; b < NUM_BANKS; b++) lastIssue[b] <= '0;
    end else begin
      cycleNo <= cycleNo + 32'd1;
      if (issueValid) begin
        lastIssue[curBank] <= cycleNo;
        seenBank[curBank]  <= 1'b1;
      end
      if (start && !busy) retCnt <= '0;
      else if (rdValid)   retCnt <= retCnt + 1'b1;
    end
  end

  // R3: same-bank accesses separated by the recovery time
  assert_bank_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && seenBank[curBank]) |-> ((cycleNo - lastIssue[curBank]) >= 32'(BANK_BUSY)));

  // R9: completion pulse lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: accesses only while a request is active
  assert_issue_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> busy);

  // R11: returned indices run in sequence
  assert_ret_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdIdx == IDX_W'(retCnt)));

  // R7: never more than the element cap returned
  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (retCnt < (IDX_W+1)'(MAX_VL)));

endmodule

bind stride_bank_sched sbs_checker #(
  .ADDR_W    (ADDR_W),
  .NUM_BANKS (NUM_BANKS),
  .BANK_BUSY (BANK_BUSY),
  .MAX_VL    (MAX_VL),
  .IDX_W     (IDX_W)
) u_sbsChk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .issueValid (issueValid),
  .issueAddr  (issueAddr),
  .rdValid    (rdValid),
  .rdIdx      (rdIdx)
);

// File: tb/stride_bank_sched_bench.sv
module stride_bank_sched_bench;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] reqBase = '0;
  logic [ADDR_W-1:0] reqStride = '0;
  logic [6:0]        reqLen = '0;
  logic              fillEn = 1'b0;
  logic [ADDR_W-1:0] fillAddr = '0;
  logic [DATA_W-1:0] fillData = '0;
  logic              busy, done, issueValid, rdValid;
  logic [ADDR_W-1:0] issueAddr;
  logic [5:0]        rdIdx;
  logic [DATA_W-1:0] rdData;

  int cyc = 0;
  int nRun = 0;
  int nFail = 0;

  stride_bank_sched u_stride_bank_sched (
    .clk(clk), .rstN(rstN), .start(start), .reqBase(reqBase),
    .reqStride(reqStride), .reqLen(reqLen), .fillEn(fillEn),
    .fillAddr(fillAddr), .fillData(fillData), .busy(busy), .done(done),
    .issueValid(issueValid), .issueAddr(issueAddr), .rdValid(rdValid),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] pat(int a);
    return (32'(a) * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        nFail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  task automatic tReset();
    @(negedge clk);
    check(!busy && !done && !rdValid && !issueValid, "R1 outputs in reset",
          {busy, done, rdValid, issueValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rdValid && !issueValid, "R1 outputs after reset",
          {busy, done, rdValid, issueValid}, 0);
  endtask

  task automatic tFill();
    for (int a = 0; a < MEMSZ; a++) begin
      @(negedge clk);
      fillEn = 1'b1; fillAddr = ADDR_W'(a); fillData = pat(a);
    end
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  // Runs one request and compares against a bank-occupancy model built from R2..R9
  task automatic runVec(int base, int stride, int len, string tTag, bit poke);
    int n, t, k, rel, got, doneRel, expDone;
    int expIss[64];
    int expAddr[64];
    int bankNext[16];
    int dataErr, ordErr, timeErr, busyErr, lateData;
    n = (len > 64) ? 64 : len;
    t = 1;
    for (int b = 0; b < 16; b++) bankNext[b] = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      a = (base + i * stride) & (MEMSZ - 1);
      expAddr[i] = a;
      if (bankNext[a & 15] > t) t = bankNext[a & 15];
      expIss[i] = t;
      bankNext[a & 15] = t + 4;
      t++;
    end
    expDone = (n == 0) ? 1 : expIss[n-1] + 12;
    got = 0; doneRel = -1; dataErr = 0; ordErr = 0; timeErr = 0; busyErr = 0;
    @(negedge clk);
    k = cyc;
    start = 1'b1; reqBase = ADDR_W'(base); reqStride = ADDR_W'(stride); reqLen = 7'(len);
    for (int w = 0; w < 2000; w++) begin
      @(negedge clk);
      start = 1'b0;
      rel = cyc - k;
      if (poke && rel == 3) begin
        start = 1'b1; reqBase = 10'd777; reqStride = 10'd16; reqLen = 7'd3;
      end
      if (rdValid) begin
        if (got < 64) begin
          if (int'(rdIdx) != got) ordErr++;
          if (rdData != pat(expAddr[got])) dataErr++;
          if (rel != expIss[got] + 12) timeErr++;
        end
        got++;
      end
      if (busy != (rel < expDone)) busyErr++;
      if (done) begin
        doneRel = rel;
        break;
      end
    end
    start = 1'b0;
    check(doneRel == expDone, "R9 done cycle", doneRel, expDone);
    check(got == n, "R7 element count", got, n);
    check(dataErr == 0, "R2 element data", dataErr, 0);
    check(ordErr == 0, "R11 element order", ordErr, 0);
    check(timeErr == 0, {tTag, " issue/return timing (R6)"}, timeErr, 0);
    check(busyErr == 0, "R9 busy window", busyErr, 0);
    // Nothing further may come out once the request is done (R10 for poked runs)
    lateData = 0;
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      if (rdValid || busy || done) lateData++;
    end
    check(lateData == 0, "R10 quiet after done", lateData, 0);
  endtask

  initial begin
    tReset();
    tFill();
    runVec(5, 1, 16, "R4", 1'b0);     // unit stride
    runVec(3, 16, 6, "R5", 1'b0);     // every element on one bank
    runVec(9, 0, 5, "R5", 1'b0);      // zero stride, same bank
    runVec(0, 8, 8, "R3", 1'b0);      // two banks alternating, stalls
    runVec(2, -3, 10, "R8", 1'b0);    // negative stride wraps below zero
    runVec(1000, 7, 12, "R8", 1'b0);  // positive wrap past the top
    runVec(0, 0, 0, "R7", 1'b0);      // empty request
    runVec(20, 1, 100, "R7", 1'b0);   // length capped at 64
    runVec(40, 3, 10, "R10", 1'b1);   // start pulse during a run
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule